// File: doc/BRIEF.md
# Receive Frame Status Forwarder

This block sits between a token-ring MAC receive path and a host-side frame buffer. Each received frame arrives as a start strobe, a run of body bytes, an end strobe, some frame-status symbols, and a status-end strobe. The block sends all of this out as a 3-bit tag with an 8-bit byte. The tag says what the byte is: start of frame, data, end of data, filler, or frame status. The block packs the received status symbols into one status word. It also takes an abort request from the host and reports a flush decision for the frame.

Every output is registered, so it appears one clock after the input that caused it. Encodings:
- Tags: 000 idle, 001 start, 010 data, 011 end of data, 101 filler, 110 frame status. Code 100 is reserved, and a consumer must treat it as filler. Code 111 is unused.
- End-of-data byte: bit 7 is the abort flag and bit 6 is the flush bit. The other bits are 0.
- Frame-status byte: bit 7 is the abort flag and bit 6 is the flush bit. Bit 5 is 0. Bits 4..0 hold the status symbols.

Top module: `rx_fs_forwarder`

## Requirements
- R1: While reset is held, and in the first cycle after it, the tag is 000 and the byte is 0.
- R2: A `rx_start` pulse while no frame is open gives one start transfer (tag 001, byte 0) on the next cycle.
- R3: In the frame body, a byte with `rx_byte_vld` appears on the next cycle with tag 010 and the same value. A body cycle with no byte gives tag 000.
- R4: A `rx_end` pulse in the body gives one end-of-data transfer (tag 011) on the next cycle. Its bit 6 is `flush_req` OR the abort flag, and its bit 7 is the abort flag.
- R5: From the cycle after end of data until the frame-status transfer, every transfer is filler: tag 101, byte 0.
- R6: A `rx_fs_end` pulse after end of data gives one frame-status transfer (tag 110) on the next cycle. Symbols fill bits 4..0 in arrival order, first symbol in bit 4. A set symbol (`rx_sym`=1) is written as 1 and a reset symbol as 0. Bits that no symbol reached are 0, and symbols after the fifth are dropped. The next cycle is idle.
- R7: If `host_abort` is high for one body cycle, or on the `rx_end` cycle, no byte of that cycle and no later byte is forwarded. End of data and frame status are still sent, each with bit 7 set and bit 6 set.
- R8: `host_abort` is ignored from the end-of-data cycle until the next frame starts. A frame that is not aborted sends bit 7 = 0 even if abort is raised in that window.
- R9: The flush bit at frame status equals the end-of-data flush bit. The one exception is when `sec_nsa` and `sec_flush_en` are both high on the `rx_fs_end` cycle; the bit is then 1. The bit never falls from 1 to 0 between the two transfers.
- R10: The tag never takes the reserved code 100 or the unused code 111.
- R11: `rx_start` while a frame is open is ignored. If `rx_end` and `rx_byte_vld` are both high, the end wins and that byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Frame start strobe |
| rx_byte_vld | input | 1 | Body byte valid |
| rx_byte | input | 8 | Body byte |
| rx_end | input | 1 | End of frame body strobe |
| rx_sym_vld | input | 1 | Status symbol valid |
| rx_sym | input | 1 | Status symbol: 1 set, 0 reset |
| rx_fs_end | input | 1 | End of status symbols strobe |
| host_abort | input | 1 | Host abort request |
| flush_req | input | 1 | Flush decision, sampled with `rx_end` |
| sec_nsa | input | 1 | Frame is a secondary next-station-addressed frame, sampled with `rx_fs_end` |
| sec_flush_en | input | 1 | Enable flushing of secondary frames, sampled with `rx_fs_end` |
| tag_o | output | 3 | Transfer tag |
| data_o | output | 8 | Transfer byte |

## Verification
A bad sequencing state shows on the tag bus one cycle later. It appears as a missing or doubled start, data leaking after end of data, or filler that never ends. A wrong symbol position counter shows only at the frame-status transfer: bits land in the wrong place, or a sixth symbol overwrites a bit. A lost abort flag shows as forwarded bytes in the cycle after the abort, and again as a clear bit 7 at the end of the frame. The bench varies frame length, gaps, symbol counts, abort timing and flush inputs so that each fault is seen.

// File: rtl/rx_fs_forwarder.sv
module rx_fs_forwarder #(
  parameter int DW   = 8,
  parameter int NSYM = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic          rx_byte_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_end,
  input  logic          rx_sym_vld,
  input  logic          rx_sym,
  input  logic          rx_fs_end,
  input  logic          host_abort,
  input  logic          flush_req,
  input  logic          sec_nsa,
  input  logic          sec_flush_en,
  output logic [2:0]    tag_o,
  output logic [DW-1:0] data_o
);
  localparam logic [2:0] T_IDLE = 3'b000, T_SOF = 3'b001, T_DATA = 3'b010,
                         T_EOD = 3'b011, T_FILL = 3'b101, T_FS = 3'b110;
  localparam int CW = $clog2(NSYM + 1);
  localparam int PADW = DW - NSYM - 2;

  typedef enum logic [1:0] {S_IDLE, S_BODY, S_FILL} st_t;
  st_t st;
  logic ab_q, fl_q;
  logic [NSYM-1:0] fld;
  logic [CW-1:0]   cnt;

  wire ab_now = ab_q | host_abort;
  wire fl_eod = ab_now | flush_req;
  wire [CW-1:0] idx = CW'(NSYM - 1) - cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ab_q <= 1'b0; fl_q <= 1'b0;
      fld <= '0; cnt <= '0;
      tag_o <= T_IDLE; data_o <= '0;
    end else begin
      tag_o  <= T_IDLE;
      data_o <= '0;
      case (st)
        S_IDLE: if (rx_start) begin
          st <= S_BODY; tag_o <= T_SOF;
          ab_q <= 1'b0; fld <= '0; cnt <= '0;
        end
        S_BODY: begin
          if (host_abort) ab_q <= 1'b1;
          if (rx_end) begin
            st <= S_FILL; tag_o <= T_EOD; fl_q <= fl_eod;
            data_o <= {ab_now, fl_eod, {(DW-2){1'b0}}};
          end else if (rx_byte_vld && !ab_now) begin
            tag_o <= T_DATA; data_o <= rx_byte;
          end
        end
        S_FILL: begin
          if (rx_fs_end) begin
            st <= S_IDLE; tag_o <= T_FS;
            data_o <= {ab_q, fl_q | (sec_nsa & sec_flush_en), {PADW{1'b0}}, fld};
          end else begin
            tag_o <= T_FILL;
            if (rx_sym_vld && cnt < CW'(NSYM)) begin
              fld[idx] <= rx_sym;
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_legal_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tag_o != 3'b100 && tag_o != 3'b111);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && st == S_IDLE) |=> tag_o == T_SOF);
  p_fill_after_eod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tag_o == T_EOD |=> (tag_o == T_FILL || tag_o == T_FS));
  p_idle_after_fs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_o == T_FS |=> tag_o == T_IDLE);
  p_no_data_after_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_o == T_DATA |-> !ab_q);
endmodule

// File: tb/sim_rx_fs_forwarder.sv
module sim_rx_fs_forwarder;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_start = 0, rx_byte_vld = 0, rx_end = 0, rx_sym_vld = 0, rx_sym = 0;
  logic rx_fs_end = 0, host_abort = 0, flush_req = 0, sec_nsa = 0, sec_flush_en = 0;
  logic [7:0] rx_byte = 0;
  logic [2:0] tag_o;
  logic [7:0] data_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_fs_forwarder u0 (.clk, .rst_n, .rx_start, .rx_byte_vld, .rx_byte, .rx_end,
    .rx_sym_vld, .rx_sym, .rx_fs_end, .host_abort, .flush_req, .sec_nsa,
    .sec_flush_en, .tag_o, .data_o);

  task automatic chk(input logic [2:0] et, input logic [7:0] ed, input string rq);
    checks++;
    if (tag_o !== et || data_o !== ed) begin
      errors++;
      $display("FAIL %s tag=%b data=%h expected tag=%b data=%h", rq, tag_o, data_o, et, ed);
    end
  endtask

  task automatic clr();
    rx_start = 0; rx_byte_vld = 0; rx_end = 0; rx_sym_vld = 0; rx_sym = 0;
    rx_fs_end = 0; host_abort = 0; flush_req = 0; sec_nsa = 0; sec_flush_en = 0;
  endtask

  function automatic logic [4:0] pack(input logic [15:0] s, input int n);
    logic [4:0] f = '0;
    for (int j = 0; j < n && j < 5; j++) f[4-j] = s[j];
    return f;
  endfunction

  // abort_at: body index for abort (nb = on end cycle, >nb = never)
  task automatic frame(input int nb, input int abort_at, input int ns, input logic [15:0] syms,
                       input bit fl, input bit sec, input bit secen, input bit late_ab, input bit gaps);
    bit ab = 0;
    logic [7:0] b;
    clr(); rx_start = 1; @(negedge clk); chk(3'b001, 8'h00, "R2");
    for (int i = 0; i < nb; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin clr(); @(negedge clk); chk(3'b000, 8'h00, "R3"); end
      clr(); b = 8'($urandom); rx_byte_vld = 1; rx_byte = b;
      if (i == 1) rx_start = 1; // R11: start inside frame ignored
      if (i == abort_at) begin host_abort = 1; ab = 1; end
      @(negedge clk);
      if (ab) chk(3'b000, 8'h00, "R7"); else chk(3'b010, b, "R3");
    end
    clr(); rx_end = 1; rx_byte_vld = 1; rx_byte = 8'hA5; flush_req = fl;  // R11: end wins
    if (abort_at == nb) begin host_abort = 1; ab = 1; end
    @(negedge clk); chk(3'b011, {ab, ab | fl, 6'b0}, "R4");
    for (int k = 0; k < ns; k++) begin
      clr(); rx_sym_vld = 1; rx_sym = syms[k]; host_abort = late_ab;
      @(negedge clk); chk(3'b101, 8'h00, "R5");
      if (gaps && k == 0) begin clr(); host_abort = late_ab; @(negedge clk); chk(3'b101, 8'h00, "R5"); end
    end
    clr(); rx_fs_end = 1; sec_nsa = sec; sec_flush_en = secen; host_abort = late_ab;
    @(negedge clk);
    chk(3'b110, {ab, (ab | fl) | (sec & secen), 1'b0, pack(syms, ns)}, late_ab ? "R8" : "R6/R9");
    clr(); @(negedge clk); chk(3'b000, 8'h00, "R6");
  endtask

  initial begin
    void'($urandom(32'd1234));
    clr();
    @(negedge clk); chk(3'b000, 8'h00, "R1");
    @(negedge clk); rst_n = 1;
    @(negedge clk); chk(3'b000, 8'h00, "R1");
    frame(4, 99, 5, 16'b10110, 0, 0, 0, 0, 0);
    frame(3, 99, 3, 16'b101, 0, 0, 0, 0, 0);       // R6 unfilled bits zero
    frame(2, 99, 7, 16'b1111111, 1, 0, 0, 0, 0);   // R6 extras dropped
    frame(5, 2, 4, 16'b0110, 0, 0, 0, 0, 0);       // R7 mid-body abort
    frame(3, 3, 2, 16'b01, 0, 0, 0, 0, 0);         // R7 abort on end cycle
    frame(3, 99, 5, 16'b00000, 0, 0, 0, 1, 0);     // R8 late abort ignored
    frame(2, 99, 5, 16'b11011, 0, 1, 1, 0, 0);     // R9 0 -> 1
    frame(2, 99, 5, 16'b11011, 0, 1, 0, 0, 0);     // R9 no change
    frame(2, 99, 5, 16'b11011, 1, 0, 1, 0, 0);     // R9 stays 1
    frame(0, 99, 0, 16'b0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 60; n++)
      frame(int'($urandom % 8), int'($urandom % 12), int'($urandom % 8), 16'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1); // R10 via tag checks
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule